// File: doc/BRIEF.md
# Frame Storage-Key Protection Checker

This block guards physical memory with a storage key held for each frame. It keeps a small table indexed by physical frame number. Each entry holds a 4-bit access key, a fetch-protect flag, and two history bits: a reference bit and a change bit. Two requesters present physical addresses. The first is the processor, whether its address was translated or not. The second is a DMA engine. Each request carries the requester's current program key and a read/write flag. One cycle later the block answers with either a grant pulse or a protection-exception pulse. Granted requests leave their trace in the frame's history bits. Because those bits belong to the physical frame and not to any mapping, every path into memory leaves the same trace, including untranslated and DMA traffic.

Supervisory software reaches the table through a management port. It can assign a key and the fetch-protect flag to a frame, read a frame's entry, or read and clear the history bits in one indivisible step. Hardware is the only agent that ever sets the history bits, and software can only clear them. A read-and-clear that coincides with traffic to the same frame returns that traffic's effect, so no reference or store is lost between the read and the clear.

Top module: `skey_guard`

## Requirements
- R1: After synchronous reset every frame has key 0, fetch-protect 0, reference 0 and change 0, and all response pulses are low.
- R2: A store is granted when the program key is 0 or equals the frame's key. Otherwise it is denied. Either outcome is a single-cycle pulse in the cycle after the request, and grant and exception never pulse together on one port.
- R3: A fetch is always granted when the frame's fetch-protect flag is 0. When the flag is 1, the fetch follows the same key rule as a store.
- R4: Program key 0 is granted for fetches and stores on every frame, whatever key and flag the frame has.
- R5: A granted access sets the frame's reference bit. A granted store also sets its change bit. A granted fetch leaves the change bit unchanged.
- R6: A denied access changes neither the reference bit nor the change bit of its frame.
- R7: The processor port and the DMA port are checked independently in the same cycle. When both are granted on the same frame, the effects of both reach the frame's history bits.
- R8: Management op 1 (set key) writes the key and fetch-protect flag of a frame and leaves its history bits alone. An access to that frame in the same cycle is checked against the previous key and flag.
- R9: Management op 2 (read) returns the frame's key, fetch-protect flag, reference bit and change bit, with a valid pulse one cycle later. The returned history bits include the effect of any access granted to that frame in the same cycle. Op 0 does nothing.
- R10: Management op 3 (read-and-clear) returns the same view as op 2, then leaves the frame with reference 0 and change 0. A granted access to that frame in the same cycle shows in the returned value and is not retained.
- R11: The frame index is address bits [17:12]. Bits [11:0] do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request (translated or untranslated) |
| cpu_addr | input | 18 | Processor physical address |
| cpu_write | input | 1 | 1 = store, 0 = fetch |
| cpu_key | input | 4 | Processor program key |
| dma_req | input | 1 | DMA access request |
| dma_addr | input | 18 | DMA physical address |
| dma_write | input | 1 | 1 = store, 0 = fetch |
| dma_key | input | 4 | DMA access key |
| sw_op | input | 2 | Management op: 0 none, 1 set key, 2 read, 3 read-and-clear |
| sw_frame | input | 6 | Frame addressed by the management op |
| sw_key | input | 4 | Key written by op 1 |
| sw_fetch_prot | input | 1 | Fetch-protect flag written by op 1 |
| cpu_grant | output | 1 | Processor access granted (pulse) |
| cpu_prot_exc | output | 1 | Processor protection exception (pulse) |
| dma_grant | output | 1 | DMA access granted (pulse) |
| dma_prot_exc | output | 1 | DMA protection exception (pulse) |
| sw_rd_valid | output | 1 | Management read data valid (pulse) |
| sw_rd_key | output | 4 | Returned frame key |
| sw_rd_fetch_prot | output | 1 | Returned fetch-protect flag |
| sw_rd_ref | output | 1 | Returned reference bit |
| sw_rd_chg | output | 1 | Returned change bit |

## Verification
A wrong key or flag in the table shows up on the very next access to that frame, as a swapped grant or exception pulse one cycle after the request. A corrupted or lost history bit stays hidden until software reads that frame. The bench therefore follows traffic with management reads, and it also runs a random mix of operations confined to a few frames, so that any drift between the table and an independent per-frame model surfaces within a few cycles. Same-cycle collisions are driven on purpose: both ports on one frame, a key update against an access, and a read-and-clear against a store. Those collisions are where a lost or duplicated history bit would appear.

// File: rtl/skey_pkg.sv
package skey_pkg;
    parameter int KEY_W       = 4;
    parameter int FRAMES      = 64;
    parameter int FRAME_SHIFT = 12;
    parameter int NPORTS      = 2;

    localparam int FIDX_W   = $clog2(FRAMES);
    localparam int PA_W     = FRAME_SHIFT + FIDX_W;
    localparam int PORT_CPU = 0;
    localparam int PORT_DMA = 1;

    typedef logic [KEY_W-1:0]  key_t;
    typedef logic [FIDX_W-1:0] fidx_t;
    typedef logic [PA_W-1:0]   paddr_t;

    typedef enum logic [1:0] {
        SW_NONE       = 2'd0,
        SW_SET_KEY    = 2'd1,
        SW_READ       = 2'd2,
        SW_READ_CLEAR = 2'd3
    } sw_op_e;

    typedef struct packed {
        key_t key;
        logic fetch_prot;
        logic ref_b;
        logic chg_b;
    } frame_ent_t;

    typedef struct packed {
        logic  valid;
        logic  write;
        key_t  key;
        fidx_t frame;
    } access_t;

    function automatic fidx_t frame_of(paddr_t a);
        return a[PA_W-1:FRAME_SHIFT];
    endfunction

    function automatic logic key_permits(key_t prog, key_t stor);
        return (prog == '0) || (prog == stor);
    endfunction
endpackage

// File: rtl/skey_decide.sv
module skey_decide
    import skey_pkg::*;
(
    input  access_t    acc_i,
    input  frame_ent_t ent_i,
    output logic       grant_o,
    output logic       deny_o
);
    logic needs_check;
    logic ok;

    always_comb begin
        needs_check = acc_i.write | ent_i.fetch_prot;
        ok          = !needs_check || key_permits(acc_i.key, ent_i.key);
        grant_o     = acc_i.valid & ok;
        deny_o      = acc_i.valid & !ok;
    end
endmodule

// File: rtl/skey_frame_table.sv
module skey_frame_table
    import skey_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  access_t    [NPORTS-1:0] acc_i,
    input  logic       [NPORTS-1:0] grant_i,
    output frame_ent_t [NPORTS-1:0] look_o,
    input  sw_op_e                  sw_op_i,
    input  fidx_t                   sw_frame_i,
    input  key_t                    sw_key_i,
    input  logic                    sw_fp_i,
    output frame_ent_t              sw_view_o
);
    frame_ent_t tbl_q [FRAMES];
    frame_ent_t tbl_d [FRAMES];

    for (genvar p = 0; p < NPORTS; p++) begin : g_look
        assign look_o[p] = tbl_q[acc_i[p].frame];
    end

    always_comb begin
        for (int f = 0; f < FRAMES; f++) begin
            tbl_d[f] = tbl_q[f];
            if (sw_op_i == SW_SET_KEY && sw_frame_i == fidx_t'(f)) begin
                tbl_d[f].key        = sw_key_i;
                tbl_d[f].fetch_prot = sw_fp_i;
            end
            for (int p = 0; p < NPORTS; p++) begin
                if (grant_i[p] && acc_i[p].frame == fidx_t'(f)) begin
                    tbl_d[f].ref_b = 1'b1;
                    if (acc_i[p].write) tbl_d[f].chg_b = 1'b1;
                end
            end
            if (sw_op_i == SW_READ_CLEAR && sw_frame_i == fidx_t'(f)) begin
                tbl_d[f].ref_b = 1'b0;
                tbl_d[f].chg_b = 1'b0;
            end
        end
    end

    always_comb begin
        sw_view_o = tbl_q[sw_frame_i];
        for (int p = 0; p < NPORTS; p++) begin
            if (grant_i[p] && acc_i[p].frame == sw_frame_i) begin
                sw_view_o.ref_b = 1'b1;
                if (acc_i[p].write) sw_view_o.chg_b = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int f = 0; f < FRAMES; f++) tbl_q[f] <= '0;
        end else begin
            for (int f = 0; f < FRAMES; f++) tbl_q[f] <= tbl_d[f];
        end
    end

    logic [FRAMES-1:0] ref_vec;
    logic [FRAMES-1:0] chg_vec;
    logic [NPORTS-1:0] wr_grant;
    for (genvar f = 0; f < FRAMES; f++) begin : g_vec
        assign ref_vec[f] = tbl_q[f].ref_b;
        assign chg_vec[f] = tbl_q[f].chg_b;
    end
    for (genvar p = 0; p < NPORTS; p++) begin : g_wr
        assign wr_grant[p] = grant_i[p] & acc_i[p].write;
    end

    // R5
    ref_rise_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(ref_vec) > $past($countones(ref_vec))) |-> $past(|grant_i));

    // R6
    chg_rise_needs_store_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(chg_vec) > $past($countones(chg_vec))) |-> $past(|wr_grant));
endmodule

// File: rtl/skey_guard.sv
module skey_guard
    import skey_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cpu_req,
    input  logic [skey_pkg::PA_W-1:0]   cpu_addr,
    input  logic                     cpu_write,
    input  logic [skey_pkg::KEY_W-1:0]  cpu_key,
    input  logic                     dma_req,
    input  logic [skey_pkg::PA_W-1:0]   dma_addr,
    input  logic                     dma_write,
    input  logic [skey_pkg::KEY_W-1:0]  dma_key,
    input  logic [1:0]               sw_op,
    input  logic [skey_pkg::FIDX_W-1:0] sw_frame,
    input  logic [skey_pkg::KEY_W-1:0]  sw_key,
    input  logic                     sw_fetch_prot,
    output logic                     cpu_grant,
    output logic                     cpu_prot_exc,
    output logic                     dma_grant,
    output logic                     dma_prot_exc,
    output logic                     sw_rd_valid,
    output logic [skey_pkg::KEY_W-1:0]  sw_rd_key,
    output logic                     sw_rd_fetch_prot,
    output logic                     sw_rd_ref,
    output logic                     sw_rd_chg
);
    access_t    [NPORTS-1:0] acc;
    frame_ent_t [NPORTS-1:0] look;
    logic       [NPORTS-1:0] grant_c;
    logic       [NPORTS-1:0] deny_c;
    logic       [NPORTS-1:0] grant_q;
    logic       [NPORTS-1:0] deny_q;
    sw_op_e                  op;
    frame_ent_t              view;
    frame_ent_t              view_q;
    logic                    rd_valid_q;

    assign op = sw_op_e'(sw_op);

    always_comb begin
        acc[PORT_CPU] = '{valid: cpu_req, write: cpu_write, key: cpu_key,
                          frame: frame_of(cpu_addr)};
        acc[PORT_DMA] = '{valid: dma_req, write: dma_write, key: dma_key,
                          frame: frame_of(dma_addr)};
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        skey_decide u_decide (
            .acc_i   (acc[p]),
            .ent_i   (look[p]),
            .grant_o (grant_c[p]),
            .deny_o  (deny_c[p])
        );

        // R2
        grant_exc_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
            !(grant_q[p] && deny_q[p]));

        // R2
        response_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
            (grant_q[p] || deny_q[p]) |-> $past(acc[p].valid));
    end

    skey_frame_table u_table (
        .clk        (clk),
        .rst        (rst),
        .acc_i      (acc),
        .grant_i    (grant_c),
        .look_o     (look),
        .sw_op_i    (op),
        .sw_frame_i (sw_frame),
        .sw_key_i   (sw_key),
        .sw_fp_i    (sw_fetch_prot),
        .sw_view_o  (view)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q    <= '0;
            deny_q     <= '0;
            rd_valid_q <= 1'b0;
            view_q     <= '0;
        end else begin
            grant_q    <= grant_c;
            deny_q     <= deny_c;
            rd_valid_q <= (op == SW_READ) || (op == SW_READ_CLEAR);
            view_q     <= view;
        end
    end

    assign cpu_grant        = grant_q[PORT_CPU];
    assign cpu_prot_exc     = deny_q[PORT_CPU];
    assign dma_grant        = grant_q[PORT_DMA];
    assign dma_prot_exc     = deny_q[PORT_DMA];
    assign sw_rd_valid      = rd_valid_q;
    assign sw_rd_key        = view_q.key;
    assign sw_rd_fetch_prot = view_q.fetch_prot;
    assign sw_rd_ref        = view_q.ref_b;
    assign sw_rd_chg        = view_q.chg_b;

    // R9
    read_valid_follows_op_chk: assert property (@(posedge clk) disable iff (rst)
        sw_rd_valid |-> $past(sw_op[1]));
endmodule

// File: tb/skey_guard_test.sv
`timescale 1ns/1ps
module skey_guard_test;
    import skey_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cpu_req = 0, cpu_write = 0, dma_req = 0, dma_write = 0, sw_fetch_prot = 0;
    logic [PA_W-1:0] cpu_addr = '0, dma_addr = '0;
    logic [KEY_W-1:0] cpu_key = '0, dma_key = '0, sw_key = '0;
    logic [1:0] sw_op = 2'd0;
    logic [FIDX_W-1:0] sw_frame = '0;
    logic cpu_grant, cpu_prot_exc, dma_grant, dma_prot_exc;
    logic sw_rd_valid, sw_rd_fetch_prot, sw_rd_ref, sw_rd_chg;
    logic [KEY_W-1:0] sw_rd_key;

    always #10 clk = ~clk;

    skey_guard uut (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_write(cpu_write), .cpu_key(cpu_key),
        .dma_req(dma_req), .dma_addr(dma_addr), .dma_write(dma_write), .dma_key(dma_key),
        .sw_op(sw_op), .sw_frame(sw_frame), .sw_key(sw_key), .sw_fetch_prot(sw_fetch_prot),
        .cpu_grant(cpu_grant), .cpu_prot_exc(cpu_prot_exc),
        .dma_grant(dma_grant), .dma_prot_exc(dma_prot_exc),
        .sw_rd_valid(sw_rd_valid), .sw_rd_key(sw_rd_key),
        .sw_rd_fetch_prot(sw_rd_fetch_prot), .sw_rd_ref(sw_rd_ref), .sw_rd_chg(sw_rd_chg)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int mkey [64];
    bit mfp  [64];
    bit mref [64];
    bit mchg [64];

    task automatic check1(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit permit(bit w, int pk, int fkey, bit fp);
        if (!w && !fp) return 1'b1;
        return (pk == 0) || (pk == fkey);
    endfunction

    // Drive one cycle at a falling edge, predict, and compare after the next rising edge.
    task automatic tick(string tag,
                        bit cv, int ca, bit cw, int ck,
                        bit dv, int da, bit dw, int dk,
                        int op, int sf, int sk, bit sfp);
        int cf, df;
        bit cg, dg;
        bit e_rv, e_rf, e_rr, e_rc;
        int e_rk;
        cpu_req = cv; cpu_addr = PA_W'(ca); cpu_write = cw; cpu_key = KEY_W'(ck);
        dma_req = dv; dma_addr = PA_W'(da); dma_write = dw; dma_key = KEY_W'(dk);
        sw_op = 2'(op); sw_frame = FIDX_W'(sf); sw_key = KEY_W'(sk); sw_fetch_prot = sfp;
        cf = (ca >> 12) & 63;
        df = (da >> 12) & 63;
        cg = cv && permit(cw, ck, mkey[cf], mfp[cf]);
        dg = dv && permit(dw, dk, mkey[df], mfp[df]);
        e_rv = (op == 2) || (op == 3);
        e_rk = mkey[sf];
        e_rf = mfp[sf];
        e_rr = mref[sf] | (cg && cf == sf) | (dg && df == sf);
        e_rc = mchg[sf] | (cg && cw && cf == sf) | (dg && dw && df == sf);
        if (op == 1) begin mkey[sf] = sk; mfp[sf] = sfp; end
        if (cg) begin mref[cf] = 1; if (cw) mchg[cf] = 1; end
        if (dg) begin mref[df] = 1; if (dw) mchg[df] = 1; end
        if (op == 3) begin mref[sf] = 0; mchg[sf] = 0; end
        @(posedge clk);
        @(negedge clk);
        check1(tag, "cpu_grant", cpu_grant, cg);
        check1(tag, "cpu_prot_exc", cpu_prot_exc, cv && !cg);
        check1(tag, "dma_grant", dma_grant, dg);
        check1(tag, "dma_prot_exc", dma_prot_exc, dv && !dg);
        check1(tag, "sw_rd_valid", sw_rd_valid, e_rv);
        if (e_rv) begin
            check1(tag, "sw_rd_key", sw_rd_key, e_rk);
            check1(tag, "sw_rd_fetch_prot", sw_rd_fetch_prot, e_rf);
            check1(tag, "sw_rd_ref", sw_rd_ref, e_rr);
            check1(tag, "sw_rd_chg", sw_rd_chg, e_rc);
        end
    endtask

    task automatic cpu(string tag, int fr, bit w, int k);
        tick(tag, 1, fr << 12, w, k, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic setkey(string tag, int fr, int k, bit fp);
        tick(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, fr, k, fp);
    endtask
    task automatic rd(string tag, int fr, int op);
        tick(tag, 0, 0, 0, 0, 0, 0, 0, 0, op, fr, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int f = 0; f < 64; f++) begin mkey[f] = 0; mfp[f] = 0; mref[f] = 0; mchg[f] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check1("R1", "cpu_grant", cpu_grant, 0);
        check1("R1", "sw_rd_valid", sw_rd_valid, 0);
        rd("R1", 0, 2);
        rd("R1", 63, 2);
        rd("R9", 5, 0);

        // key rule for stores and fetches
        setkey("R8", 3, 5, 0);
        cpu("R2", 3, 1, 5);
        cpu("R2", 3, 1, 6);
        cpu("R4", 3, 1, 0);
        cpu("R3", 3, 0, 6);
        setkey("R8", 3, 5, 1);
        rd("R8", 3, 2);
        cpu("R3", 3, 0, 6);
        cpu("R3", 3, 0, 5);
        cpu("R4", 3, 0, 0);
        rd("R5", 3, 2);
        rd("R10", 3, 3);
        rd("R10", 3, 2);

        // denied access leaves history alone
        setkey("R6", 7, 2, 1);
        cpu("R6", 7, 1, 9);
        cpu("R6", 7, 0, 9);
        rd("R6", 7, 2);

        // fetch sets reference only
        cpu("R5", 8, 0, 4);
        rd("R5", 8, 2);

        // both ports at once, different and same frame
        tick("R7", 1, 11 << 12, 0, 1, 1, 10 << 12, 1, 0, 0, 0, 0, 0);
        rd("R7", 10, 2);
        rd("R7", 11, 2);
        tick("R7", 1, 12 << 12, 0, 3, 1, 12 << 12, 1, 7, 0, 0, 0, 0);
        rd("R7", 12, 2);
        tick("R7", 1, 12 << 12, 1, 0, 1, 12 << 12, 0, 0, 0, 0, 0, 0);
        rd("R7", 12, 2);

        // key update racing an access: old key applies
        tick("R8", 1, 13 << 12, 1, 4, 0, 0, 0, 0, 1, 13, 4, 0);
        cpu("R8", 13, 1, 4);
        rd("R8", 13, 2);

        // read-and-clear racing a store
        tick("R10", 0, 0, 0, 0, 1, 14 << 12, 1, 0, 3, 14, 0, 0);
        rd("R10", 14, 2);
        tick("R9", 1, 15 << 12, 1, 0, 0, 0, 0, 0, 2, 15, 0, 0);

        // offset bits do not matter
        setkey("R11", 20, 9, 1);
        tick("R11", 1, (20 << 12) | 12'hFFF, 0, 9, 1, (21 << 12) | 12'h5A3, 1, 9, 0, 0, 0, 0);
        tick("R11", 1, (20 << 12) | 12'h001, 1, 3, 0, 0, 0, 0, 2, 20, 0, 0);
        rd("R11", 21, 2);

        // random mix on a few frames
        for (int i = 0; i < 600; i++) begin
            tick("R2",
                 1'($urandom_range(0, 1)), ($urandom_range(0, 5) << 12) | $urandom_range(0, 4095),
                 1'($urandom_range(0, 1)), $urandom_range(0, 3),
                 1'($urandom_range(0, 1)), ($urandom_range(0, 5) << 12) | $urandom_range(0, 4095),
                 1'($urandom_range(0, 1)), $urandom_range(0, 3),
                 $urandom_range(0, 3), $urandom_range(0, 5), $urandom_range(0, 3),
                 1'($urandom_range(0, 1)));
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule